// File: doc/BRIEF.md
# Four-Lane Jitter Compliance Pattern Sequencer

This block plays out a fixed jitter and crosstalk test pattern on a four-lane byte datapath, one 32-bit column per clock with one byte per lane. Each repetition opens with a start-and-preamble prefix, then a single disparity-control row, then the pattern body, then a fixed checksum row, and ends with a short idle gap before the next repetition begins. The body is kept as a compact list of rows. Each row has a repeat count, and the sequencer holds a row on the output for that many columns before moving to the next one.

The body is laid out so that the lanes never run in step with each other. Lanes 0 and 2 run their low-transition-density stretch first and their high-density stretch after it. Lanes 1 and 3 run the same material in the reverse order. A static select picks one of two variants. The full-length variant plays the body twice. The half-length variant plays it once and uses a different control row and checksum. Because the gap is an odd number of columns, each lane's running disparity alternates from one repetition to the next. The variant is taken up only when a new repetition starts, and dropping the enable parks the sequencer on idle.

Top module: `jpat_seq`

## Requirements
- R1: While reset is held, and after reset until enable is seen high, every lane carries the idle byte 0x07, `ctrl_o` is 4'b1111 and `sop_o` is low.
- R2: A repetition opens with two prefix columns. The first holds bytes FB 55 55 55 for lanes 0..3, with `ctrl_o`=4'b0001 and `sop_o` high for that one column only. The second holds 55 55 55 D5.
- R3: The column after the prefix is the disparity-control row. It holds D5 55 07 07 (lanes 0..3) when `long_sel_i`=1 and 55 55 13 07 when `long_sel_i`=0.
- R4: Every body row is held for its repeat count: 40 columns for 7E B5 7E B5 and B5 7E B5 7E, 84 columns for the all-7E row, and one column for every other row. No run of identical columns is longer than 84.
- R5: In every body column, lane 0 equals lane 2 and lane 1 equals lane 3. Lane 0 differs from lane 1 except during the all-7E run.
- R6: The long variant plays the 188-column body twice, restarting at the 7E B5 7E B5 run, which gives 383 columns between start strobes. The short variant plays the body once, which gives 195 columns.
- R7: The last pattern column is the checksum row: F7 C6 DB D2 for the long variant and E6 42 BC 62 for the short variant.
- R8: Three idle columns (0x07 in every lane, `ctrl_o`=4'b1111) follow the checksum row, and the next prefix follows them at once.
- R9: `long_sel_i` is taken only on the column where `sop_o` rises. A change in the middle of a repetition leaves that repetition's length and content unchanged.
- R10: If `en_i` is low at a clock edge, the next column is idle. When `en_i` is seen high again, the next column is the first prefix column.
- R11: Prefix columns other than the first, and all control, body and checksum columns, have `ctrl_o`=4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Run enable; low parks the sequencer on idle |
| long_sel_i | input | 1 | Variant select: 1 long, 0 short |
| data_o | output | 32 | Column data, lane 0 in bits 7:0 |
| ctrl_o | output | 4 | Per-lane control-character flag |
| sop_o | output | 1 | One-column strobe on the first prefix column |

## Verification
The stream is tried under four stimuli: steady short-variant repetitions, steady long-variant repetitions, a variant flip in the middle of a long repetition, and an enable drop in the middle of a pattern. Each stimulus separates a different class of fault. The steady runs catch wrong row contents and wrong repeat counts. The mid-pattern flip shows whether the select is taken too early. The enable drop shows whether parking and the restart from the prefix work. A behavioural model compares every column, and run-length and lane-pair monitors check the body shape separately from that model.

// File: rtl/jpat_pkg.sv
package jpat_pkg;

  typedef enum logic [2:0] {
    PH_GAP  = 3'd0,
    PH_PRE  = 3'd1,
    PH_CTRL = 3'd2,
    PH_BODY = 3'd3,
    PH_CRC  = 3'd4
  } phase_e;

  localparam int LANES     = 4;
  localparam int BYTE_W    = 8;
  localparam int COL_W     = LANES * BYTE_W;
  localparam int BODY_ROWS = 27;
  localparam int IDX_W     = 5;

  localparam logic [7:0] K_IDLE  = 8'h07;
  localparam logic [7:0] K_START = 8'hFB;
  localparam logic [7:0] B_PRE   = 8'h55;
  localparam logic [7:0] B_SFD   = 8'hD5;

  // lane 0 occupies the low byte
  function automatic logic [COL_W-1:0] pack4(input logic [7:0] b0, input logic [7:0] b1,
                                             input logic [7:0] b2, input logic [7:0] b3);
    return {b3, b2, b1, b0};
  endfunction

  // Body row contents; the alternating stretches are computed from the index parity
  function automatic logic [COL_W-1:0] body_word(input logic [IDX_W-1:0] idx);
    logic [7:0] alt, inv;
    alt = idx[0] ? 8'hEB : 8'hF4;
    inv = idx[0] ? 8'hF4 : 8'hEB;
    if (idx == 5'd0)       return pack4(8'h7E, 8'hB5, 8'h7E, 8'hB5);
    else if (idx <= 5'd8)  return pack4(8'h7E, alt, 8'h7E, alt);
    else if (idx == 5'd9)  return pack4(8'h7E, 8'h7E, 8'h7E, 8'h7E);
    else if (idx <= 5'd16) return pack4(alt, 8'h7E, alt, 8'h7E);
    else if (idx == 5'd17) return pack4(8'hAB, 8'h7E, 8'hAB, 8'h7E);
    else if (idx == 5'd18) return pack4(8'hB5, 8'h7E, 8'hB5, 8'h7E);
    else if (idx <= 5'd25) return pack4(alt, inv, alt, inv);
    else                   return pack4(8'hF4, 8'hAB, 8'hF4, 8'hAB);
  endfunction

  function automatic int unsigned body_len(input logic [IDX_W-1:0] idx);
    case (idx)
      5'd0, 5'd18: return 40;
      5'd9:        return 84;
      default:     return 1;
    endcase
  endfunction

endpackage

// File: rtl/jpat_rom.sv
module jpat_rom
  import jpat_pkg::*;
#(
  parameter int REP_W    = 8,
  parameter int GAP_COLS = 3
) (
  input  phase_e                 phase_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic                   long_i,
  output logic [COL_W-1:0]       word_o,
  output logic [LANES-1:0]       ctrl_o,
  output logic [REP_W-1:0]       len_o,
  output logic [IDX_W-1:0]       rows_o
);

  always_comb begin
    word_o = pack4(K_IDLE, K_IDLE, K_IDLE, K_IDLE);
    ctrl_o = '1;
    len_o  = REP_W'(1);
    rows_o = IDX_W'(1);
    case (phase_i)
      PH_GAP: begin
        rows_o = IDX_W'(GAP_COLS);
      end
      PH_PRE: begin
        rows_o = IDX_W'(2);
        if (idx_i == '0) begin
          word_o = pack4(K_START, B_PRE, B_PRE, B_PRE);
          ctrl_o = 4'b0001;
        end else begin
          word_o = pack4(B_PRE, B_PRE, B_PRE, B_SFD);
          ctrl_o = '0;
        end
      end
      PH_CTRL: begin
        word_o = long_i ? pack4(8'hD5, 8'h55, 8'h07, 8'h07)
                        : pack4(8'h55, 8'h55, 8'h13, 8'h07);
        ctrl_o = '0;
      end
      PH_BODY: begin
        rows_o = IDX_W'(BODY_ROWS);
        word_o = body_word(idx_i);
        len_o  = REP_W'(body_len(idx_i));
        ctrl_o = '0;
      end
      PH_CRC: begin
        word_o = long_i ? pack4(8'hF7, 8'hC6, 8'hDB, 8'hD2)
                        : pack4(8'hE6, 8'h42, 8'hBC, 8'h62);
        ctrl_o = '0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/jpat_repeat.sv
module jpat_repeat #(
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [REP_W-1:0] len_i,
  output logic [REP_W-1:0] rep_o,
  output logic             done_o
);

  assign done_o = (rep_o == len_i - REP_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i)  rep_o <= '0;
    else if (done_o)      rep_o <= '0;
    else                  rep_o <= rep_o + REP_W'(1);
  end

endmodule

// File: rtl/jpat_seq.sv
module jpat_seq
  import jpat_pkg::*;
#(
  parameter int REP_W    = 8,
  parameter int GAP_COLS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_i,
  input  logic        long_sel_i,
  output logic [31:0] data_o,
  output logic [3:0]  ctrl_o,
  output logic        sop_o
);

  phase_e           phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             pass_q, pass_d;
  logic             var_q, var_d;
  logic             parked_q;

  logic [REP_W-1:0] rep_q, rep_len;
  logic [IDX_W-1:0] phase_rows;
  logic             row_done, last_row, restart;

  jpat_rom #(.REP_W(REP_W), .GAP_COLS(GAP_COLS)) u_rom (
    .phase_i(phase_q), .idx_i(idx_q), .long_i(var_q),
    .word_o(data_o), .ctrl_o(ctrl_o), .len_o(rep_len), .rows_o(phase_rows)
  );

  jpat_repeat #(.REP_W(REP_W)) u_rep (
    .clk(clk), .rst_n(rst_n), .clr_i(!en_i || parked_q),
    .len_i(rep_len), .rep_o(rep_q), .done_o(row_done)
  );

  assign sop_o    = !parked_q && (phase_q == PH_PRE) && (idx_q == '0);
  assign last_row = row_done && (idx_q == phase_rows - IDX_W'(1));
  // a new repetition begins here; the variant is taken only on this edge
  assign restart  = en_i && (parked_q || (phase_q == PH_GAP && last_row));

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    pass_d  = pass_q;
    var_d   = var_q;
    if (restart) begin
      phase_d = PH_PRE;
      idx_d   = '0;
      var_d   = long_sel_i;
    end else if (last_row) begin
      idx_d = '0;
      case (phase_q)
        PH_PRE:  phase_d = PH_CTRL;
        PH_CTRL: begin
          phase_d = PH_BODY;
          pass_d  = 1'b0;
        end
        PH_BODY: begin
          if (var_q && !pass_q) pass_d = 1'b1;
          else                  phase_d = PH_CRC;
        end
        PH_CRC:  phase_d = PH_GAP;
        default: phase_d = PH_GAP;
      endcase
    end else if (row_done) begin
      idx_d = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      phase_q  <= PH_GAP;
      idx_q    <= '0;
      pass_q   <= 1'b0;
      parked_q <= 1'b1;
      if (!rst_n) var_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      idx_q    <= idx_d;
      pass_q   <= pass_d;
      var_q    <= var_d;
      parked_q <= 1'b0;
    end
  end

endmodule

// File: rtl/jpat_seq_chk.sv
module jpat_seq_chk #(
  parameter int REP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_i,
  input logic [31:0]      data_o,
  input logic [3:0]       ctrl_o,
  input logic             sop_o,
  input logic             var_q,
  input logic [REP_W-1:0] rep_q,
  input logic [REP_W-1:0] rep_len
);

  AST_SOP_START: assert property (@(posedge clk) disable iff (!rst_n)
    sop_o |-> (ctrl_o == 4'b0001 && data_o[7:0] == 8'hFB)); // R2

  AST_SOP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (sop_o && en_i) |=> (!sop_o && data_o == 32'hD5555555 && ctrl_o == 4'b0000)); // R2

  AST_PARK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (data_o == 32'h07070707 && ctrl_o == 4'hF && !sop_o)); // R10

  AST_CTRL_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o == 4'b0000 || ctrl_o == 4'b0001 || ctrl_o == 4'b1111)); // R11

  AST_VAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(var_q) |-> sop_o); // R9

  AST_REP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rep_q < rep_len); // R4

endmodule

bind jpat_seq jpat_seq_chk #(.REP_W(REP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .data_o(data_o), .ctrl_o(ctrl_o),
  .sop_o(sop_o), .var_q(var_q), .rep_q(rep_q), .rep_len(rep_len)
);

// File: tb/tb_jpat_seq.sv
`timescale 1ns/1ps
module tb_jpat_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_i = 1'b0;
  logic        long_sel_i = 1'b0;
  logic [31:0] data_o;
  logic [3:0]  ctrl_o;
  logic        sop_o;

  always #4 clk = ~clk; // 125 MHz

  jpat_seq dut (.clk(clk), .rst_n(rst_n), .en_i(en_i), .long_sel_i(long_sel_i),
                .data_o(data_o), .ctrl_o(ctrl_o), .sop_o(sop_o));

  int checks = 0, errors = 0, cycles = 0;

  // region codes: 0 parked, 1 prefix, 2 control row, 3 body, 4 checksum, 5 gap
  typedef struct { logic [31:0] d; logic [3:0] c; bit s; int r; } col_t;
  col_t exp_q[$];
  int   pos = 0;
  bit   parked = 1'b1;

  function automatic string tag(int r);
    case (r)
      0: return "R10"; 1: return "R2"; 2: return "R3";
      3: return "R5";  4: return "R7"; default: return "R8";
    endcase
  endfunction

  function automatic logic [31:0] w(logic [7:0] a, logic [7:0] b, logic [7:0] c, logic [7:0] d);
    return {d, c, b, a};
  endfunction

  function automatic void put(logic [31:0] d, logic [3:0] c, bit s, int r, int n);
    for (int i = 0; i < n; i++) exp_q.push_back('{d, c, s, r});
  endfunction

  function automatic void build(bit lng);
    exp_q.delete();
    put(w(8'hFB, 8'h55, 8'h55, 8'h55), 4'b0001, 1, 1, 1);
    put(w(8'h55, 8'h55, 8'h55, 8'hD5), 4'b0000, 0, 1, 1);
    put(lng ? w(8'hD5, 8'h55, 8'h07, 8'h07) : w(8'h55, 8'h55, 8'h13, 8'h07), 0, 0, 2, 1);
    for (int p = 0; p < (lng ? 2 : 1); p++) begin
      put(w(8'h7E, 8'hB5, 8'h7E, 8'hB5), 0, 0, 3, 40);
      for (int k = 0; k < 8; k++) begin
        logic [7:0] x; x = (k % 2 == 0) ? 8'hEB : 8'hF4;
        put(w(8'h7E, x, 8'h7E, x), 0, 0, 3, 1);
      end
      put(32'h7E7E7E7E, 0, 0, 3, 84);
      for (int k = 0; k < 7; k++) begin
        logic [7:0] x; x = (k % 2 == 0) ? 8'hF4 : 8'hEB;
        put(w(x, 8'h7E, x, 8'h7E), 0, 0, 3, 1);
      end
      put(w(8'hAB, 8'h7E, 8'hAB, 8'h7E), 0, 0, 3, 1);
      put(w(8'hB5, 8'h7E, 8'hB5, 8'h7E), 0, 0, 3, 40);
      for (int k = 0; k < 7; k++) begin
        logic [7:0] x, y;
        x = (k % 2 == 0) ? 8'hEB : 8'hF4;
        y = (k % 2 == 0) ? 8'hF4 : 8'hEB;
        put(w(x, y, x, y), 0, 0, 3, 1);
      end
      put(w(8'hF4, 8'hAB, 8'hF4, 8'hAB), 0, 0, 3, 1);
    end
    put(lng ? w(8'hF7, 8'hC6, 8'hDB, 8'hD2) : w(8'hE6, 8'h42, 8'hBC, 8'h62), 0, 0, 4, 1);
    put(32'h07070707, 4'hF, 0, 5, 3);
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // reference model, advanced on each edge from the inputs seen there
  always @(posedge clk) begin
    if (!rst_n || !en_i) parked = 1'b1;
    else if (parked) begin parked = 1'b0; pos = 0; build(long_sel_i); end
    else begin
      pos++;
      if (pos >= exp_q.size()) begin pos = 0; build(long_sel_i); end
    end
  end

  int run7e = 0, max_run7e = 0, run_any = 0, max_run_any = 0;
  int lane_bad = 0, ctrl_bad = 0;
  logic [31:0] prev_d = '0;

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      col_t e;
      int r;
      if (parked) e = '{32'h07070707, 4'hF, 0, 0};
      else        e = exp_q[pos];
      r = e.r;
      check(data_o === e.d, tag(r), "data", data_o, e.d);
      check(ctrl_o === e.c, (r >= 1 && r <= 4) ? "R11" : tag(r), "ctrl", 32'(ctrl_o), 32'(e.c));
      check(sop_o === e.s, "R2", "sop", 32'(sop_o), 32'(e.s));
      if (r >= 2 && r <= 4 && ctrl_o != 4'b0000) ctrl_bad++;
      if (r == 3) begin
        if (data_o[7:0] != data_o[23:16] || data_o[15:8] != data_o[31:24]) lane_bad++;
        if (data_o != 32'h7E7E7E7E && data_o[7:0] == data_o[15:8]) lane_bad++;
      end
      run7e = (data_o == 32'h7E7E7E7E) ? run7e + 1 : 0;
      if (run7e > max_run7e) max_run7e = run7e;
      run_any = (data_o == prev_d && r >= 2 && r <= 4) ? run_any + 1 : 1;
      if (run_any > max_run_any) max_run_any = run_any;
      prev_d = data_o;
    end
  end

  task automatic wait_sop();
    do @(negedge clk); while (!sop_o);
  endtask

  task automatic period(output int n);
    wait_sop();
    n = 0;
    do begin @(negedge clk); n++; end while (!sop_o);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    check(data_o == 32'h07070707 && ctrl_o == 4'hF && !sop_o, "R1", "reset idle",
          data_o, 32'h07070707);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(data_o == 32'h07070707 && ctrl_o == 4'hF, "R1", "idle before enable", data_o, 32'h07070707);
    en_i = 1'b1;
    @(negedge clk);
    check(sop_o == 1'b1, "R2", "first column after enable", 32'(sop_o), 1);
    period(n);
    check(n == 195, "R8", "short period", n, 195);
    period(n);
    check(n == 195, "R6", "short period repeat", n, 195);
    check(max_run7e == 84, "R4", "all-7E run length", max_run7e, 84);

    long_sel_i = 1'b1;
    wait_sop();
    period(n);
    check(n == 383, "R6", "long period", n, 383);

    // flip the variant in the middle of a long repetition
    wait_sop();
    n = 0;
    repeat (100) begin @(negedge clk); n++; end
    long_sel_i = 1'b0;
    do begin @(negedge clk); n++; end while (!sop_o);
    check(n == 383, "R9", "long repetition kept after mid flip", n, 383);
    period(n);
    check(n == 195, "R9", "short taken at next start", n, 195);

    // enable drop in the middle of a pattern
    repeat (60) @(negedge clk);
    en_i = 1'b0;
    @(negedge clk);
    check(data_o == 32'h07070707 && ctrl_o == 4'hF && !sop_o, "R10", "idle after drop",
          data_o, 32'h07070707);
    repeat (10) @(negedge clk);
    en_i = 1'b1;
    @(negedge clk);
    check(sop_o == 1'b1 && data_o == 32'h555555FB, "R10", "restart at prefix", data_o, 32'h555555FB);
    period(n);
    check(n == 195, "R8", "period after restart", n, 195);

    check(lane_bad == 0, "R5", "lane pairing violations", lane_bad, 0);
    check(ctrl_bad == 0, "R11", "ctrl set on data columns", ctrl_bad, 0);
    check(max_run_any == 84, "R4", "longest identical run", max_run_any, 84);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule